// File: doc/BRIEF.md
# Pipelined Mixed-Width Integer Execution Unit

This unit is the integer execution stage of a 64-bit virtual-machine core. Each cycle it can accept one operation. The operation has an opcode, a first operand A and a second operand B. B is either a register value or an 8-bit immediate carried in the instruction. The unit returns a 64-bit result C together with a valid strobe.

The operation set is as follows:
- wrapping 64-bit add and subtract;
- 32-bit add, subtract, AND, OR and XOR, each of which clears the upper result half;
- five multiplies, giving low and high product halves for both signednesses;
- logical and arithmetic shifts and both rotate directions, all with a 6-bit count.

Every operation takes the same fixed number of cycles, so results leave in issue order with no gaps. This holds even though the multiplier is internally pipelined. The caller therefore needs no reorder logic or tag matching.

Top module: `int_exec_unit`

## Requirements
- R1: After reset, `res_vld` is low and `res_c` is zero. Whenever `res_vld` is low, `res_c` is zero.
- R2: An operation accepted on the clock edge where `op_vld` is high produces `res_vld` high with its result exactly 3 edges later (parameter LAT). Operations issued on consecutive cycles produce results on consecutive cycles, in issue order.
- R3: ADD64 (code 0) and SUB64 (code 1) return A+B and A−B modulo 2^64.
- R4: ADD32 (2), SUB32 (3), AND32 (4), OR32 (5) and XOR32 (6) use only bits 31:0 of each operand. They return the 32-bit result in bits 31:0 with bits 63:32 zero.
- R5: MULLO64 (7) returns the low 64 bits of the unsigned 128-bit product. MULHU64 (8) returns the high 64 bits of that product.
- R6: MUL32U (9) and MUL32S (10) multiply bits 31:0 of each operand, as unsigned and as signed values respectively, and return the full 64-bit product.
- R7: MULHS64 (11) returns the high 64 bits of the signed 128-bit product of A and B.
- R8: SHL (12) and SHR (13) shift A by B[5:0] and fill vacated bits with zero. B bits above bit 5 have no effect on any shift or rotate.
- R9: SAR (14) shifts A right by B[5:0] and fills vacated bits with copies of A[63].
- R10: ROL (15) and ROR (16) rotate A by B[5:0]. A count of zero returns A unchanged.
- R11: When `op_imm_sel` is high, B is `op_imm` zero-extended to 64 bits and `op_b` is ignored.
- R12: Opcode values 17 to 31 produce a valid result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Operation strobe |
| op_code | input | 5 | Operation select |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Register form of operand B |
| op_imm | input | 8 | Immediate form of operand B |
| op_imm_sel | input | 1 | High selects the immediate as B |
| res_vld | output | 1 | Result strobe |
| res_c | output | 64 | Result C |

## Verification
The checker follows every cycle and confirms four things:
- the valid strobe appears exactly LAT cycles after issue;
- the result is zero whenever it is not valid;
- 32-bit operations leave the upper half clear;
- the sign fill of SAR, the zero fill of SHR and the identity of a zero-count rotate hold for every operand seen.

Full numeric correctness can only be shown by the bench scenarios, which compare each result against an independent model. Those scenarios cover:
- add wraparound;
- the high product halves, including the signed corners at the most negative value;
- the masking of the count bits above bit 5;
- immediate selection;
- unassigned opcodes;
- a stream of back-to-back operations that mixes multiply and non-multiply work.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD64  = 5'd0,
    OP_SUB64  = 5'd1,
    OP_ADD32  = 5'd2,
    OP_SUB32  = 5'd3,
    OP_AND32  = 5'd4,
    OP_OR32   = 5'd5,
    OP_XOR32  = 5'd6,
    OP_MULLO  = 5'd7,
    OP_MULHU  = 5'd8,
    OP_MUL32U = 5'd9,
    OP_MUL32S = 5'd10,
    OP_MULHS  = 5'd11,
    OP_SHL    = 5'd12,
    OP_SHR    = 5'd13,
    OP_SAR    = 5'd14,
    OP_ROL    = 5'd15,
    OP_ROR    = 5'd16
  } op_e;

  function automatic logic is_mul(input logic [OPW-1:0] op);
    return (op >= OP_MULLO) && (op <= OP_MULHS);
  endfunction

  function automatic logic is_half(input logic [OPW-1:0] op);
    return (op >= OP_ADD32) && (op <= OP_XOR32);
  endfunction
endpackage

// File: rtl/iexu_basic.sv
module iexu_basic
  import iexu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int HALF = XLEN / 2;

  logic [HALF-1:0] al, bl;
  assign al = a[HALF-1:0];
  assign bl = b[HALF-1:0];

  always_comb begin
    res = '0;
    case (op)
      OP_ADD64: res = a + b;
      OP_SUB64: res = a - b;
      OP_ADD32: res = {{HALF{1'b0}}, al + bl};
      OP_SUB32: res = {{HALF{1'b0}}, al - bl};
      OP_AND32: res = {{HALF{1'b0}}, al & bl};
      OP_OR32:  res = {{HALF{1'b0}}, al | bl};
      OP_XOR32: res = {{HALF{1'b0}}, al ^ bl};
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift
  import iexu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int SHW = $clog2(XLEN);
  localparam logic [SHW:0] XLV = (SHW+1)'(XLEN);

  logic [SHW-1:0] cnt;
  logic [SHW:0]   inv;
  assign cnt = b[SHW-1:0];
  assign inv = XLV - {1'b0, cnt};

  always_comb begin
    res = '0;
    case (op)
      OP_SHL:  res = a << cnt;
      OP_SHR:  res = a >> cnt;
      OP_SAR:  res = $unsigned($signed(a) >>> cnt);
      OP_ROL:  res = (a << cnt) | (a >> inv);
      OP_ROR:  res = (a >> cnt) | (a << inv);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/iexu_mul.sv
module iexu_mul
  import iexu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LAT  = 3
) (
  input  logic            clk,
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = 2 * (XLEN + 1);
  localparam int PST  = LAT - 2;

  logic signed [XLEN:0] ea, eb, ra, rb;
  logic                 hi_c, hi_r;

  always_comb begin
    ea   = {1'b0, a};
    eb   = {1'b0, b};
    hi_c = 1'b0;
    case (op)
      OP_MULHU:  hi_c = 1'b1;
      OP_MULHS:  begin
        ea   = {a[XLEN-1], a};
        eb   = {b[XLEN-1], b};
        hi_c = 1'b1;
      end
      OP_MUL32U: begin
        ea = {{(HALF+1){1'b0}}, a[HALF-1:0]};
        eb = {{(HALF+1){1'b0}}, b[HALF-1:0]};
      end
      OP_MUL32S: begin
        ea = {{(HALF+1){a[HALF-1]}}, a[HALF-1:0]};
        eb = {{(HALF+1){b[HALF-1]}}, b[HALF-1:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    ra   <= ea;
    rb   <= eb;
    hi_r <= hi_c;
  end

  logic signed [PW-1:0] prod;
  assign prod = ra * rb;

  logic [PW-1:0] pp [PST];
  logic          ph [PST];

  always_ff @(posedge clk) begin
    pp[0] <= prod;
    ph[0] <= hi_r;
  end

  for (genvar s = 1; s < PST; s++) begin : g_pstage
    always_ff @(posedge clk) begin
      pp[s] <= pp[s-1];
      ph[s] <= ph[s-1];
    end
  end

  assign res = ph[PST-1] ? pp[PST-1][2*XLEN-1:XLEN] : pp[PST-1][XLEN-1:0];
endmodule

// File: rtl/iexu_delay.sv
module iexu_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (DEPTH == 0) begin : g_wire
    assign q = d;
  end else begin : g_regs
    logic [W-1:0] sr [DEPTH];
    always_ff @(posedge clk) begin
      if (rst) sr[0] <= '0;
      else     sr[0] <= d;
    end
    for (genvar i = 1; i < DEPTH; i++) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst) sr[i] <= '0;
        else     sr[i] <= sr[i-1];
      end
    end
    assign q = sr[DEPTH-1];
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 8,
  parameter int LAT  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_vld,
  input  logic [OPW-1:0]  op_code,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [IMMW-1:0] op_imm,
  input  logic            op_imm_sel,
  output logic            res_vld,
  output logic [XLEN-1:0] res_c
);
  localparam int DW = XLEN + 2;

  logic [XLEN-1:0] b_eff, basic_res, shift_res, mul_res;
  assign b_eff = op_imm_sel ? {{(XLEN-IMMW){1'b0}}, op_imm} : op_b;

  iexu_basic #(.XLEN(XLEN)) u_basic (
    .op(op_code), .a(op_a), .b(b_eff), .res(basic_res)
  );

  iexu_shift #(.XLEN(XLEN)) u_shift (
    .op(op_code), .a(op_a), .b(b_eff), .res(shift_res)
  );

  iexu_mul #(.XLEN(XLEN), .LAT(LAT)) u_mul (
    .clk(clk), .op(op_code), .a(op_a), .b(b_eff), .res(mul_res)
  );

  logic [DW-1:0] d_in, d_out;
  assign d_in = {op_vld, is_mul(op_code), basic_res | shift_res};

  iexu_delay #(.W(DW), .DEPTH(LAT-1)) u_align (
    .clk(clk), .rst(rst), .d(d_in), .q(d_out)
  );

  logic            al_vld, al_mul;
  logic [XLEN-1:0] al_res;
  assign {al_vld, al_mul, al_res} = d_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_c   <= '0;
    end else begin
      res_vld <= al_vld;
      res_c   <= al_vld ? (al_mul ? mul_res : al_res) : '0;
    end
  end
endmodule

// File: rtl/iexu_checker.sv
module iexu_checker
  import iexu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 8,
  parameter int LAT  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            op_vld,
  input logic [OPW-1:0]  op_code,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [IMMW-1:0] op_imm,
  input logic            op_imm_sel,
  input logic            res_vld,
  input logic [XLEN-1:0] res_c
);
  localparam int SHW = $clog2(XLEN);

  logic           sh_v [LAT];
  logic [OPW-1:0] sh_op [LAT];
  logic [XLEN-1:0] sh_a [LAT];
  logic [SHW-1:0] sh_n [LAT];
  logic [SHW-1:0] cnt_in;

  assign cnt_in = op_imm_sel ? op_imm[SHW-1:0] : op_b[SHW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin
        sh_v[i] <= 1'b0; sh_op[i] <= '0; sh_a[i] <= '0; sh_n[i] <= '0;
      end
    end else begin
      sh_v[0] <= op_vld; sh_op[0] <= op_code; sh_a[0] <= op_a; sh_n[0] <= cnt_in;
      for (int i = 1; i < LAT; i++) begin
        sh_v[i] <= sh_v[i-1]; sh_op[i] <= sh_op[i-1];
        sh_a[i] <= sh_a[i-1]; sh_n[i] <= sh_n[i-1];
      end
    end
  end

  logic           t_v;
  logic [OPW-1:0] t_op;
  logic [XLEN-1:0] t_a;
  logic [SHW-1:0] t_n;
  assign t_v = sh_v[LAT-1];
  assign t_op = sh_op[LAT-1];
  assign t_a = sh_a[LAT-1];
  assign t_n = sh_n[LAT-1];

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    res_vld == t_v);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> res_c == '0);

  assert_upper_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (res_vld && is_half(t_op)) |-> res_c[XLEN-1:XLEN/2] == '0);

  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (res_vld && t_op == OP_SHR && t_n != '0) |-> !res_c[XLEN-1]);

  assert_sign_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (res_vld && t_op == OP_SAR) |-> res_c[XLEN-1] == t_a[XLEN-1]);

  assert_rot_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (res_vld && (t_op == OP_ROL || t_op == OP_ROR) && t_n == '0) |-> res_c == t_a);
endmodule

bind int_exec_unit iexu_checker #(.XLEN(XLEN), .IMMW(IMMW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .op_vld(op_vld), .op_code(op_code), .op_a(op_a),
  .op_b(op_b), .op_imm(op_imm), .op_imm_sel(op_imm_sel),
  .res_vld(res_vld), .res_c(res_c)
);

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_vld = 1'b0;
  logic [4:0]  op_code = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [7:0]  op_imm = '0;
  logic        op_imm_sel = 1'b0;
  logic        res_vld;
  logic [63:0] res_c;

  always #2.5 clk = ~clk;

  int_exec_unit u0 (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_code(op_code), .op_a(op_a),
    .op_b(op_b), .op_imm(op_imm), .op_imm_sel(op_imm_sel),
    .res_vld(res_vld), .res_c(res_c)
  );

  typedef struct {
    logic [63:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] model(input logic [4:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [127:0] pu;
    logic signed [127:0] ps;
    logic signed [63:0] p32;
    int n;
    n = int'(b[5:0]);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return {32'd0, a[31:0] + b[31:0]};
      3: return {32'd0, a[31:0] - b[31:0]};
      4: return {32'd0, a[31:0] & b[31:0]};
      5: return {32'd0, a[31:0] | b[31:0]};
      6: return {32'd0, a[31:0] ^ b[31:0]};
      7: begin pu = {64'd0, a} * {64'd0, b}; return pu[63:0]; end
      8: begin pu = {64'd0, a} * {64'd0, b}; return pu[127:64]; end
      9: return {32'd0, a[31:0]} * {32'd0, b[31:0]};
      10: begin
        p32 = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
        return p32;
      end
      11: begin
        ps = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
        return ps[127:64];
      end
      12: return a << n;
      13: return a >> n;
      14: begin
        logic [63:0] r;
        r = a >> n;
        for (int i = 0; i < 64; i++) if (i >= 64 - n) r[i] = a[63];
        return r;
      end
      15: return (n == 0) ? a : ((a << n) | (a >> (64 - n)));
      16: return (n == 0) ? a : ((a >> n) | (a << (64 - n)));
      default: return 64'd0;
    endcase
  endfunction

  task automatic issue(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic sel, input logic [7:0] imm, input string tag);
    item_t it;
    @(negedge clk);
    op_vld = 1'b1; op_code = op; op_a = a; op_b = b; op_imm_sel = sel; op_imm = imm;
    it.exp = model(op, a, sel ? {56'd0, imm} : b);
    it.due = cyc + 3;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_vld = 1'b0; op_code = '0; op_a = '0; op_b = '0; op_imm = '0; op_imm_sel = 1'b0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_vld) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected result act=%h exp=none", res_c);
        end else begin
          item_t it;
          it = q.pop_front();
          if (it.due != cyc || res_c !== it.exp) begin
            errors++;
            $display("FAIL %s act=%h@%0d exp=%h@%0d", it.tag, res_c, cyc, it.exp, it.due);
          end
        end
      end else begin
        if (res_c !== 64'd0) begin
          checks++; errors++;
          $display("FAIL R1 idle result act=%h exp=0", res_c);
        end
        if (q.size() != 0 && q[0].due <= cyc) begin
          checks++; errors++;
          $display("FAIL R2 missing result for %s act=none exp=%h", q[0].tag, q[0].exp);
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || res_c !== 64'd0) begin
      errors++;
      $display("FAIL R1 reset state act=%b/%h exp=0/0", res_vld, res_c);
    end
    rst = 1'b0;
    idle(2);

    // R3 wrap
    issue(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, "R3 add64 wrap");
    issue(1, 64'd0, 64'd1, 0, 0, "R3 sub64 wrap");
    issue(0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 0, 0, "R3 add64");
    // R4 half width
    issue(2, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0002, 0, 0, "R4 add32");
    issue(3, 64'hDEAD_0000_0000_0000, 64'hBEEF_0000_0000_0001, 0, 0, "R4 sub32");
    issue(4, 64'hFFFF_FFFF_F0F0_F0F0, 64'hFFFF_FFFF_FF00_FF00, 0, 0, "R4 and32");
    issue(5, 64'h8000_0000_0F0F_0000, 64'h8000_0000_0000_F0F0, 0, 0, "R4 or32");
    issue(6, 64'hFFFF_FFFF_AAAA_5555, 64'h0123_4567_FFFF_FFFF, 0, 0, "R4 xor32");
    // R5 unsigned 64x64
    issue(7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R5 mullo");
    issue(8, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R5 mulhu");
    issue(8, 64'h8000_0000_0000_0000, 64'd6, 0, 0, "R5 mulhu small");
    // R6 32x32
    issue(9, 64'h1234_5678_FFFF_FFFF, 64'h9ABC_0000_FFFF_FFFF, 0, 0, "R6 mul32u");
    issue(10, 64'h0000_0000_FFFF_FFFE, 64'hFFFF_FFFF_0000_0003, 0, 0, "R6 mul32s neg");
    issue(10, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0, 0, "R6 mul32s min");
    // R7 signed high
    issue(11, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, "R7 mulhs min");
    issue(11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 0, 0, "R7 mulhs neg");
    issue(11, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, "R7 mulhs max");
    idle(2);
    // R8 shifts, upper count bits ignored
    issue(12, 64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFC4, 0, 0, "R8 shl masked");
    issue(13, 64'h8000_0000_0000_0000, 64'd63, 0, 0, "R8 shr 63");
    issue(13, 64'hF000_0000_0000_0000, 64'h100, 0, 0, "R8 shr count0");
    // R9 arithmetic
    issue(14, 64'h8000_0000_0000_0010, 64'd4, 0, 0, "R9 sar neg");
    issue(14, 64'h4000_0000_0000_0000, 64'd62, 0, 0, "R9 sar pos");
    // R10 rotates
    issue(15, 64'h8000_0000_0000_0001, 64'd4, 0, 0, "R10 rol 4");
    issue(16, 64'h8000_0000_0000_0001, 64'd4, 0, 0, "R10 ror 4");
    issue(15, 64'hDEAD_BEEF_0BAD_F00D, 64'h40, 0, 0, "R10 rol zero");
    issue(16, 64'hDEAD_BEEF_0BAD_F00D, 64'd0, 0, 0, "R10 ror zero");
    // R11 immediate
    issue(0, 64'd100, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8'hF0, "R11 imm add");
    issue(12, 64'd1, 64'd0, 1, 8'hC5, "R11 imm shl masked");
    issue(9, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8'hFF, "R11 imm mul32u");
    // R12 unassigned
    issue(17, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, "R12 code17");
    issue(31, 64'h1234, 64'h5678, 0, 0, "R12 code31");
    idle(1);
    // R2 interleaved stream
    for (int k = 0; k < 24; k++) begin
      logic [63:0] a, b;
      a = {32'h9E37_79B9 * (k + 1), 32'h7F4A_7C15 ^ (k * 32'h0101_0101)};
      b = {32'hC2B2_AE35 + k, 32'h1656_67B1 * (k + 3)};
      issue(5'(k % 17), a, b, 0, 0, "R2 stream");
    end
    idle(8);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 pending results act=%0d exp=0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule